// File: doc/BRIEF.md
# Floating-point condition branch sequencer

This block resolves branches that test one of eight floating-point condition-code bits in a core with a single architectural delay slot. Each cycle it may accept one decoded branch: a 5-bit selector field, a 16-bit signed word offset, the branch's own PC, the current condition codes, and a flag that says whether the branch itself sits in a delay slot.

One cycle later it presents a registered result. The result gives the continuation PC, whether the branch was taken, whether the delay-slot instruction must be annulled, and whether the branch was illegal. A one-cycle pending pulse marks the window in which the delay-slot instruction is outstanding. Fetch, exception vectoring and execution of the slot instruction belong to the surrounding pipeline. The decision reads the condition codes exactly as presented with the branch; a compare issued in the same cycle is not forwarded.

Top module: `fpc_branch_seq`

## Requirements
- R1: After reset, and until the first branch is accepted, every output is zero, including next_pc_o.
- R2: The tested condition bit is cc_i[rt_i[4:2]]. No other condition bit affects the decision.
- R3: The form is taken from rt_i[1:0]. Codes 0 and 2 branch when the selected bit is 0. Codes 1 and 3 branch when it is 1.
- R4: A taken legal branch gives next_pc_o = pc_i + 4 + (sign-extended offset_i shifted left by 2). Negative offsets wrap modulo 2^32.
- R5: A legal branch that is not taken gives next_pc_o = pc_i + 8.
- R6: Codes 2 and 3 are the likely forms. They raise annul_o only when not taken, and leave it low when taken.
- R7: Codes 0 and 1 never raise annul_o.
- R8: A branch accepted with in_slot_i high raises illegal_o. It leaves taken_o, annul_o and slot_pend_o low and does not change next_pc_o.
- R9: The result is registered. res_valid_o equals br_valid_i of the previous cycle. In a cycle after no branch, taken_o, annul_o, illegal_o and slot_pend_o are low and next_pc_o holds its value.
- R10: slot_pend_o is high for exactly the one cycle after a legal branch, whether the slot is annulled or not, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A condition branch is presented this cycle |
| rt_i | input | 5 | Selector: [4:2] condition index, [1:0] form |
| offset_i | input | 16 | Signed word offset |
| pc_i | input | 32 | PC of the branch |
| cc_i | input | 8 | Floating-point condition codes |
| in_slot_i | input | 1 | Branch itself is in a delay slot |
| res_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Continuation PC after the slot |
| annul_o | output | 1 | Annul the delay-slot instruction |
| illegal_o | output | 1 | Branch rejected as illegal |
| slot_pend_o | output | 1 | Delay-slot instruction pending |

## Verification
A wrong condition index or form decode shows up one cycle after the branch, as a flipped taken_o together with a next_pc_o that is off by the offset, and for likely forms as a wrong annul_o. A bad target adder shows up only on taken branches, so both positive and negative offsets are driven. Corrupt result-hold state shows as next_pc_o moving after an illegal branch or an idle cycle, which is visible in the very next cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    FORM_FALSE   = 2'd0,
    FORM_TRUE    = 2'd1,
    FORM_FALSE_L = 2'd2,
    FORM_TRUE_L  = 2'd3
  } br_form_e;

  typedef struct packed {
    logic taken;
    logic annul;
  } br_dec_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
#(
  parameter int CC_N = 8,
  parameter int RT_W = 5
) (
  input  logic [RT_W-1:0] rt_i,
  input  logic [CC_N-1:0] cc_i,
  output br_dec_t         dec_o
);
  localparam int IDX_W = $clog2(CC_N);

  br_form_e         form;
  logic [IDX_W-1:0] idx;
  logic             bit_sel;
  logic             sense;
  logic             likely;

  assign form    = br_form_e'(rt_i[1:0]);
  assign idx     = rt_i[2 +: IDX_W];
  assign bit_sel = cc_i[idx];

  always_comb begin
    sense  = 1'b0;
    likely = 1'b0;
    unique case (form)
      FORM_FALSE:   begin sense = 1'b0; likely = 1'b0; end
      FORM_TRUE:    begin sense = 1'b1; likely = 1'b0; end
      FORM_FALSE_L: begin sense = 1'b0; likely = 1'b1; end
      FORM_TRUE_L:  begin sense = 1'b1; likely = 1'b1; end
      default:      begin sense = 1'b0; likely = 1'b0; end
    endcase
  end

  assign dec_o.taken = (bit_sel == sense);
  assign dec_o.annul = likely & (bit_sel != sense);
endmodule

// File: rtl/fpc_target.sv
module fpc_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  tgt_o,
  output logic [PC_W-1:0]  fall_o
);
  localparam int EXT_W = PC_W - OFF_W - 2;

  logic [PC_W-1:0] slot_pc;
  logic [PC_W-1:0] disp;

  assign slot_pc = pc_i + PC_W'(4);
  assign disp    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
  assign tgt_o   = slot_pc + disp;
  assign fall_o  = slot_pc + PC_W'(4);
endmodule

// File: rtl/fpc_branch_seq.sv
module fpc_branch_seq
  import fpc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int CC_N  = 8,
  parameter int RT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic [RT_W-1:0]  rt_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [CC_N-1:0]  cc_i,
  input  logic             in_slot_i,
  output logic             res_valid_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             annul_o,
  output logic             illegal_o,
  output logic             slot_pend_o
);
  br_dec_t         dec;
  logic [PC_W-1:0] tgt_pc;
  logic [PC_W-1:0] fall_pc;
  logic            legal;

  fpc_decode #(.CC_N(CC_N), .RT_W(RT_W)) u_dec (
    .rt_i  (rt_i),
    .cc_i  (cc_i),
    .dec_o (dec)
  );

  fpc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i     (pc_i),
    .offset_i (offset_i),
    .tgt_o    (tgt_pc),
    .fall_o   (fall_pc)
  );

  assign legal = br_valid_i & ~in_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      annul_o     <= 1'b0;
      illegal_o   <= 1'b0;
      slot_pend_o <= 1'b0;
    end else begin
      res_valid_o <= br_valid_i;
      illegal_o   <= br_valid_i & in_slot_i;
      taken_o     <= legal & dec.taken;
      annul_o     <= legal & dec.annul;
      slot_pend_o <= legal;
      if (legal) next_pc_o <= dec.taken ? tgt_pc : fall_pc;
    end
  end
endmodule

// File: rtl/fpc_branch_seq_chk.sv
module fpc_branch_seq_chk #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int CC_N  = 8,
  parameter int RT_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             br_valid_i,
  input logic [RT_W-1:0]  rt_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             in_slot_i,
  input logic             res_valid_o,
  input logic             taken_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             annul_o,
  input logic             illegal_o,
  input logic             slot_pend_o
);
  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(br_valid_i));

  assert_illegal_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && !annul_o && !slot_pend_o));

  assert_illegal_holds_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && in_slot_i) |=> $stable(next_pc_o));

  assert_annul_only_untaken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> !taken_o);

  assert_no_annul_plain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !rt_i[1]) |=> !annul_o);

  assert_fall_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !in_slot_i) |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'(8)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> ($stable(next_pc_o) && !slot_pend_o && !taken_o));
endmodule

bind fpc_branch_seq fpc_branch_seq_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .CC_N(CC_N), .RT_W(RT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_valid_i  (br_valid_i),
  .rt_i        (rt_i),
  .pc_i        (pc_i),
  .in_slot_i   (in_slot_i),
  .res_valid_o (res_valid_o),
  .taken_o     (taken_o),
  .next_pc_o   (next_pc_o),
  .annul_o     (annul_o),
  .illegal_o   (illegal_o),
  .slot_pend_o (slot_pend_o)
);

// File: tb/fpc_branch_seq_tb_top.sv
`timescale 1ns/1ps
module fpc_branch_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_valid_i = 1'b0;
  logic [4:0]  rt_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] pc_i = '0;
  logic [7:0]  cc_i = '0;
  logic        in_slot_i = 1'b0;
  logic        res_valid_o, taken_o, annul_o, illegal_o, slot_pend_o;
  logic [31:0] next_pc_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_npc = '0;

  always #10 clk_i = ~clk_i;

  fpc_branch_seq dut_i (
    .clk_i, .rst_ni, .br_valid_i, .rt_i, .offset_i, .pc_i, .cc_i, .in_slot_i,
    .res_valid_o, .taken_o, .next_pc_o, .annul_o, .illegal_o, .slot_pend_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive on negedge, sample 1 ns after the capturing posedge
  task automatic issue(input logic [4:0] rt, input logic [15:0] off, input logic [31:0] pc,
                       input logic [7:0] cc, input logic slot);
    @(negedge clk_i);
    br_valid_i = 1'b1; rt_i = rt; offset_i = off; pc_i = pc; cc_i = cc; in_slot_i = slot;
    @(posedge clk_i); #1;
    br_valid_i = 1'b0; in_slot_i = 1'b0;
  endtask

  task automatic branch_chk(input string tag, input logic [4:0] rt, input logic [15:0] off,
                            input logic [31:0] pc, input logic [7:0] cc);
    logic bitv, tk, an;
    bitv = cc[rt[4:2]];
    tk = (bitv == rt[0]);
    an = rt[1] & ~tk;
    exp_npc = tk ? pc + 32'd4 + {{14{off[15]}}, off, 2'b00} : pc + 32'd8;
    issue(rt, off, pc, cc, 1'b0);
    chk({tag, " valid R9"}, 32'(res_valid_o), 32'd1);
    chk({tag, " taken R3"}, 32'(taken_o), 32'(tk));
    chk({tag, tk ? " npc R4" : " npc R5"}, next_pc_o, exp_npc);
    chk({tag, rt[1] ? " annul R6" : " annul R7"}, 32'(annul_o), 32'(an));
    chk({tag, " pend R10"}, 32'(slot_pend_o), 32'd1);
    chk({tag, " illegal R8"}, 32'(illegal_o), 32'd0);
  endtask

  task automatic test_reset();
    chk("reset valid R1", 32'(res_valid_o), 32'd0);
    chk("reset taken R1", 32'(taken_o), 32'd0);
    chk("reset npc R1", next_pc_o, 32'd0);
    chk("reset flags R1", {28'd0, annul_o, illegal_o, slot_pend_o, 1'b0}, 32'd0);
  endtask

  task automatic test_cc_index();
    for (int i = 0; i < 8; i++) begin
      // only bit i set: true form on index i takes, index (i+1)%8 does not (R2)
      branch_chk("ccidx R2", 5'((i << 2) | 1), 16'h0010, 32'h1000 + 32'(i * 64), 8'(1 << i));
      branch_chk("ccother R2", 5'((((i + 1) % 8) << 2) | 1), 16'h0010, 32'h2000, 8'(1 << i));
    end
  endtask

  task automatic test_forms();
    for (int f = 0; f < 4; f++) begin
      branch_chk("form cc0 R3", 5'((3 << 2) | f), 16'h0100, 32'h4000_0000, 8'h00);
      branch_chk("form cc1 R3", 5'((3 << 2) | f), 16'h0100, 32'h4000_0000, 8'h08);
    end
  endtask

  task automatic test_neg_offset();
    branch_chk("negoff R4", 5'b00000, 16'hFFFE, 32'h0000_1000, 8'h00);
    branch_chk("wrap R4", 5'b00001, 16'h8000, 32'h0000_0010, 8'h01);
  endtask

  task automatic test_illegal();
    logic [31:0] held;
    branch_chk("pre ill R5", 5'b00001, 16'h0004, 32'h0000_3000, 8'h00);
    held = next_pc_o;
    issue(5'b00011, 16'h0040, 32'h0000_5000, 8'h01, 1'b1);
    chk("ill flag R8", 32'(illegal_o), 32'd1);
    chk("ill quiet R8", {29'd0, taken_o, annul_o, slot_pend_o}, 32'd0);
    chk("ill npc R8", next_pc_o, held);
  endtask

  task automatic test_idle();
    logic [31:0] held;
    branch_chk("pre idle R4", 5'b00010, 16'h0020, 32'h0000_8000, 8'h00);
    held = next_pc_o;
    @(posedge clk_i); #1;
    chk("idle valid R9", 32'(res_valid_o), 32'd0);
    chk("idle pend R10", 32'(slot_pend_o), 32'd0);
    chk("idle flags R9", {29'd0, taken_o, annul_o, illegal_o}, 32'd0);
    chk("idle npc R9", next_pc_o, held);
  endtask

  initial begin
    fork
      begin
        #5; test_reset();
        @(negedge clk_i); rst_ni = 1'b1;
        @(posedge clk_i); #1; test_reset();
        test_cc_index();
        test_forms();
        test_neg_offset();
        test_illegal();
        test_idle();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule